// File: doc/BRIEF.md
# Indexed-Window Vectored Interrupt Controller

This block gathers 64 interrupt request lines and turns them into a stream of one-cycle delivery strobes toward a processor. Each strobe carries the number of the source being delivered and its vector. Every source has an enable bit and a trigger-mode bit. Software reaches these two 64-bit control words through an index/data window. It first writes an 8-bit index, and later data writes and reads act on the word that index selects.

Service of a source ends when software writes that source's number into a separate acknowledge port. Between delivery and acknowledge the source is held in service and is not offered again. Sixteen legacy bus request lines are merged onto a fixed band of sources. One of those legacy lines has no connection.

Top module: `vec_intr_hub`

## Requirements
- R1: After reset the mask word reads all ones, the trigger word reads all zeros, and `cpu_int` is low.
- R2: A data write updates the word chosen by the last written index: 0x40 selects the mask word and 0x50 selects the trigger word. `dat_rdata` shows the selected word. Any other index reads as zero, and data writes to it change neither word.
- R3: A source whose mask bit is 1 is never delivered. Its edge latch can still be set, and it is delivered once it is unmasked.
- R4: A source whose trigger bit is 0 is edge-sensitive. A rising input edge latches a pending request that survives the input falling, and one edge gives one delivery.
- R5: A source whose trigger bit is 1 is level-sensitive. It is pending only while its input is high. If it is acknowledged while still high it is delivered again; if its input is low at acknowledge it is not.
- R6: Among sources that are unmasked, pending and not in service, the lowest-numbered one is delivered first. Each delivery is a one-cycle `cpu_int` strobe, with `cpu_src` = n and `cpu_vec` = 0x800 + 16*n. A request appears as a strobe two clock edges after it is driven, and one source can be delivered per cycle.
- R7: A delivered source is in service and is not delivered again until `ack_src` = n is written with `ack_we`. That write also clears an edge source's pending latch.
- R8: Legacy request k (0..15) drives source k+7, with the exception of request 13, which has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 64 | Direct interrupt request lines, bit n = source n |
| leg_req | input | 16 | Legacy bus request lines |
| idx_we | input | 1 | Index register write strobe |
| idx_wdata | input | 8 | Index value |
| dat_we | input | 1 | Data window write strobe |
| dat_wdata | input | 64 | Data window write value |
| dat_rdata | output | 64 | Data window read value (selected word) |
| ack_we | input | 1 | Acknowledge write strobe |
| ack_src | input | 6 | Number of the source whose service ends |
| cpu_int | output | 1 | One-cycle delivery strobe |
| cpu_src | output | 6 | Source number being delivered |
| cpu_vec | output | 16 | Vector of the delivered source |

## Verification
The bench probes four situations:
- An edge that arrives while the source is masked. A design that drops such an edge never delivers after unmask; a design that ignores the mask delivers too early.
- Two sources raised in the same cycle. A broken priority encoder delivers the higher-numbered one first.
- A level source acknowledged while still asserted, and again after it falls. A design that wrongly latches level inputs keeps redelivering, and one that forgets to re-evaluate stays silent.
- The disconnected legacy request 13 and an unmapped index. Either would show up as a stray strobe or a corrupted mask word.

// File: rtl/hub_pkg.sv
package hub_pkg;
  localparam int NSRC       = 64;
  localparam int SRC_W      = $clog2(NSRC);
  localparam int IDX_W      = 8;
  localparam int VEC_W      = 16;
  localparam logic [IDX_W-1:0] IDX_MASK = 8'h40;
  localparam logic [IDX_W-1:0] IDX_TRIG = 8'h50;
  localparam logic [VEC_W-1:0] VEC_BASE = 16'h0800;
  localparam int VEC_SHIFT  = 4;
  localparam int LEG_N      = 16;
  localparam int LEG_BASE   = 7;
  localparam int LEG_NC     = 13;
endpackage

// File: rtl/hub_regs.sv
module hub_regs
  import hub_pkg::*;
#(
  parameter int N  = NSRC,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_we,
  input  logic [IW-1:0] idx_wdata,
  input  logic          dat_we,
  input  logic [N-1:0]  dat_wdata,
  output logic [N-1:0]  dat_rdata,
  output logic [N-1:0]  mask_o,
  output logic [N-1:0]  trig_o
);
  logic [IW-1:0] idx_q, idx_d;
  logic [N-1:0]  mask_q, mask_d, trig_q, trig_d;
  logic          sel_mask, sel_trig;

  assign sel_mask = (idx_q == IDX_MASK);
  assign sel_trig = (idx_q == IDX_TRIG);

  always_comb begin
    idx_d  = idx_q;
    mask_d = mask_q;
    trig_d = trig_q;
    if (idx_we) idx_d = idx_wdata;
    if (dat_we && sel_mask) mask_d = dat_wdata;
    if (dat_we && sel_trig) trig_d = dat_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      mask_q <= '1;
      trig_q <= '0;
    end else begin
      idx_q  <= idx_d;
      mask_q <= mask_d;
      trig_q <= trig_d;
    end
  end

  always_comb begin
    dat_rdata = '0;
    if (sel_mask) dat_rdata = mask_q;
    else if (sel_trig) dat_rdata = trig_q;
  end

  assign mask_o = mask_q;
  assign trig_o = trig_q;

  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && sel_mask) |=> (mask_q == $past(dat_wdata))); // R2
  AST_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && !sel_mask && !sel_trig) |=> ($stable(mask_q) && $stable(trig_q))); // R2
endmodule

// File: rtl/hub_srcs.sv
module hub_srcs
  import hub_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] trig_i,
  input  logic [N-1:0] ack_i,
  input  logic [N-1:0] take_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] isv_o
);
  for (genvar n = 0; n < N; n++) begin : g_src
    logic smp_q, smp_d, lat_q, lat_d, isv_q, isv_d;

    always_comb begin
      smp_d = req_i[n];
      lat_d = (req_i[n] & ~smp_q) | (lat_q & ~ack_i[n]);
      isv_d = take_i[n] | (isv_q & ~ack_i[n]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        smp_q <= 1'b0;
        lat_q <= 1'b0;
        isv_q <= 1'b0;
      end else begin
        smp_q <= smp_d;
        lat_q <= lat_d;
        isv_q <= isv_d;
      end
    end

    assign pend_o[n] = trig_i[n] ? smp_q : lat_q;
    assign isv_o[n]  = isv_q;

    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_q && !ack_i[n]) |=> lat_q); // R4
  end
endmodule

// File: rtl/hub_pick.sv
module hub_pick
  import hub_pkg::*;
#(
  parameter int N  = NSRC,
  localparam int SW = $clog2(N)
) (
  input  logic [N-1:0]  cand_i,
  output logic          found_o,
  output logic [SW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand_i[i]) begin
        found_o = 1'b1;
        idx_o   = SW'(i);
      end
    end
  end
endmodule

// File: rtl/vec_intr_hub.sv
module vec_intr_hub
  import hub_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_req,
  input  logic [LEG_N-1:0]  leg_req,
  input  logic              idx_we,
  input  logic [IDX_W-1:0]  idx_wdata,
  input  logic              dat_we,
  input  logic [NSRC-1:0]   dat_wdata,
  output logic [NSRC-1:0]   dat_rdata,
  input  logic              ack_we,
  input  logic [SRC_W-1:0]  ack_src,
  output logic              cpu_int,
  output logic [SRC_W-1:0]  cpu_src,
  output logic [VEC_W-1:0]  cpu_vec
);
  logic [NSRC-1:0]  leg_map, req_all, mask, trig, pend, isv, cand, ack_hit, take;
  logic             found;
  logic [SRC_W-1:0] pick;
  logic             int_q, int_d;
  logic [SRC_W-1:0] src_q, src_d;

  always_comb begin
    leg_map = '0;
    for (int k = 0; k < LEG_N; k++) begin
      leg_map[LEG_BASE + k] = leg_req[k] && (k != LEG_NC);
    end
  end
  assign req_all = src_req | leg_map;

  hub_regs #(.N(NSRC), .IW(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .idx_wdata(idx_wdata),
    .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
    .mask_o(mask), .trig_o(trig)
  );

  assign ack_hit = ack_we ? (NSRC'(1) << ack_src) : '0;
  assign take    = found ? (NSRC'(1) << pick) : '0;

  hub_srcs #(.N(NSRC)) u_srcs (
    .clk(clk), .rst_n(rst_n), .req_i(req_all), .trig_i(trig),
    .ack_i(ack_hit), .take_i(take), .pend_o(pend), .isv_o(isv)
  );

  assign cand = pend & ~mask & ~isv;

  hub_pick #(.N(NSRC)) u_pick (.cand_i(cand), .found_o(found), .idx_o(pick));

  always_comb begin
    int_d = found;
    src_d = found ? pick : src_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q <= 1'b0;
      src_q <= '0;
    end else begin
      int_q <= int_d;
      src_q <= src_d;
    end
  end

  assign cpu_int = int_q;
  assign cpu_src = src_q;
  assign cpu_vec = VEC_BASE + (VEC_W'(src_q) << VEC_SHIFT);

  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_int |-> ((($past(mask) >> cpu_src) & NSRC'(1)) == '0)); // R3
  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_int |-> (($past(cand) & ((NSRC'(1) << cpu_src) - NSRC'(1))) == '0)); // R6
  AST_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_int |-> isv[cpu_src]); // R7
  AST_NO_REDELIVER: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_int |=> !(cpu_int && cpu_src == $past(cpu_src))); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_we |=> (!isv[$past(ack_src)] || (cpu_int && cpu_src == $past(ack_src)))); // R7
endmodule

// File: tb/vec_intr_hub_bench.sv
module vec_intr_hub_bench;
  import hub_pkg::*;

  logic clk = 1'b0;
  logic rst_n;
  logic [NSRC-1:0]  src_req;
  logic [LEG_N-1:0] leg_req;
  logic idx_we, dat_we, ack_we;
  logic [IDX_W-1:0] idx_wdata;
  logic [NSRC-1:0]  dat_wdata, dat_rdata;
  logic [SRC_W-1:0] ack_src, cpu_src;
  logic cpu_int;
  logic [VEC_W-1:0] cpu_vec;

  int n_tests = 0, n_fail = 0, n_unexp = 0;
  int exp_q[$];
  string exp_tag[$];
  bit done = 0;

  always #5 clk = ~clk;

  vec_intr_hub u_vec_intr_hub (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .leg_req(leg_req),
    .idx_we(idx_we), .idx_wdata(idx_wdata), .dat_we(dat_we),
    .dat_wdata(dat_wdata), .dat_rdata(dat_rdata), .ack_we(ack_we),
    .ack_src(ack_src), .cpu_int(cpu_int), .cpu_src(cpu_src), .cpu_vec(cpu_vec)
  );

  // Monitor: compares each delivery strobe against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && cpu_int) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++; n_unexp++;
        $display("FAIL unexpected delivery (R3/R7): actual src %0d, expected none", cpu_src);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = exp_tag.pop_front();
        if (cpu_src != SRC_W'(e) || cpu_vec != VEC_W'(16'h800 + 16 * e)) begin
          n_fail++;
          $display("FAIL %s: actual src %0d vec %h, expected src %0d vec %h",
                   t, cpu_src, cpu_vec, e, 16'h800 + 16 * e);
        end
      end
    end
  end

  task automatic expect_src(input int s, input string tag);
    exp_q.push_back(s);
    exp_tag.push_back(tag);
  endtask

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h, expected %h", tag, act, expv);
    end
  endtask

  task automatic wr_idx(input logic [7:0] v);
    @(negedge clk); idx_we = 1'b1; idx_wdata = v;
    @(negedge clk); idx_we = 1'b0;
  endtask

  task automatic wr_dat(input logic [63:0] v);
    @(negedge clk); dat_we = 1'b1; dat_wdata = v;
    @(negedge clk); dat_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] i, input logic [63:0] expv, input string tag);
    wr_idx(i);
    check(dat_rdata == expv, tag, dat_rdata, expv);
  endtask

  task automatic ack(input int s);
    @(negedge clk); ack_we = 1'b1; ack_src = SRC_W'(s);
    @(negedge clk); ack_we = 1'b0;
  endtask

  task automatic drain(input int maxc, input string tag);
    for (int c = 0; c < maxc && exp_q.size() != 0; c++) @(negedge clk);
    #1;
    check(exp_q.size() == 0, tag, 64'(exp_q.size()), 64'd0);
  endtask

  task automatic quiet(input int cyc, input string tag);
    int u0;
    u0 = n_unexp;
    repeat (cyc) @(negedge clk);
    #1;
    check(n_unexp == u0 && exp_q.size() == 0, tag, 64'(n_unexp - u0), 64'd0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] m;
    rst_n = 1'b0; src_req = '0; leg_req = '0; idx_we = 0; idx_wdata = '0;
    dat_we = 0; dat_wdata = '0; ack_we = 0; ack_src = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cpu_int == 1'b0, "R1 int low", 64'(cpu_int), 64'd0);
    rd_chk(8'h40, '1, "R1 mask reset");
    rd_chk(8'h50, '0, "R1 trig reset");

    // R2: window access, stray index
    m = ~((64'd1 << 3) | (64'd1 << 9) | (64'd1 << 12) | (64'd1 << 20) | (64'd1 << 40));
    wr_idx(8'h40); wr_dat(m);
    check(dat_rdata == m, "R2 mask readback", dat_rdata, m);
    rd_chk(8'h33, '0, "R2 stray index reads zero");
    wr_dat(64'h0);
    rd_chk(8'h40, m, "R2 stray write ignored");

    // R3: edge while masked is latched, delivered on unmask
    @(negedge clk); src_req[5] = 1'b1;
    quiet(6, "R3 masked source silent");
    @(negedge clk); src_req[5] = 1'b0;
    expect_src(5, "R3 delivery after unmask");
    wr_idx(8'h40); wr_dat(m & ~(64'd1 << 5));
    drain(6, "R3 drained");
    ack(5);

    // R4 / R7: edge source gives one delivery per edge
    expect_src(3, "R4 edge delivery");
    @(negedge clk); src_req[3] = 1'b1;
    drain(6, "R4 drained");
    quiet(6, "R7 no redelivery before ack");
    @(negedge clk); src_req[3] = 1'b0;
    quiet(4, "R4 edge kept after fall, still in service");
    ack(3);
    quiet(6, "R7 ack clears edge latch");

    // R6: priority between two sources in the same cycle
    expect_src(9, "R6 lower first");
    expect_src(40, "R6 higher second");
    @(negedge clk); src_req[9] = 1'b1; src_req[40] = 1'b1;
    drain(8, "R6 drained");
    @(negedge clk); src_req[9] = 1'b0; src_req[40] = 1'b0;
    ack(9); ack(40);
    quiet(5, "R6 nothing left");

    // R5: level source on 40
    wr_idx(8'h50); wr_dat(64'd1 << 40);
    expect_src(40, "R5 level delivery");
    @(negedge clk); src_req[40] = 1'b1;
    drain(6, "R5 drained");
    quiet(5, "R7 level held in service");
    expect_src(40, "R5 redelivery while high");
    ack(40);
    drain(6, "R5 redelivery drained");
    @(negedge clk); src_req[40] = 1'b0;
    @(negedge clk);
    ack(40);
    quiet(6, "R5 low at ack gives nothing");

    // R8: legacy mapping
    @(negedge clk); leg_req[13] = 1'b1;
    quiet(6, "R8 legacy 13 not connected");
    expect_src(12, "R8 legacy 5 to source 12");
    @(negedge clk); leg_req[5] = 1'b1;
    drain(6, "R8 drained");
    @(negedge clk); leg_req[5] = 1'b0; leg_req[13] = 1'b0;
    ack(12);
    quiet(5, "R8 quiet after ack");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule